// File: doc/BRIEF.md
# Single-Bit and Scaled-Index Execution Unit

This execution unit serves two groups of integer operations on an XLEN-wide operand. The first group acts on one bit of rs1: it can set, clear or flip that bit, or return it on its own. The bit index comes either from the low bits of rs2 or from an immediate field. The second group does address arithmetic. It adds rs2 to rs1 shifted left by 1, 2 or 3. Its unsigned-word forms first zero-extend the low 32 bits of rs1, and the group also has a plain zero-extended word add and a zero-extended word shift-left.

The decoder supplies a 4-bit operation code, the two source operands, the immediate, and one enable per group. The unit registers a result and an illegal flag, and both appear one clock after the inputs. A rejected operation gives a result of zero. The unsigned-word forms are accepted only when XLEN is 64.

Top module: `sbsa_unit`

## Requirements
- R1: Op codes 0, 1 and 2 (set, clear, invert) combine rs1 with a mask that has a single 1 at the bit index, using OR, AND-NOT and XOR respectively.
- R2: Op code 3 (extract) returns bit `index` of rs1 in result bit 0, with all other result bits zero.
- R3: For op codes 0 to 3 the index is rs2 bits log2(XLEN)-1:0, so an index of XLEN or more wraps. Op codes 4 to 7 act exactly like op codes 0 to 3, but take the index from imm_i.
- R4: Op codes 8, 9 and 10 return (rs1 << N) + rs2 with N = 1, 2 and 3, modulo 2^XLEN.
- R5: Op codes 11, 12 and 13 zero-extend rs1 bits 31:0, shift the result left by N = 1, 2 and 3, and add rs2.
- R6: Op code 14 returns the zero-extended rs1 bits 31:0 plus rs2.
- R7: Op code 15 places rs1 bits 31:0 at bit position imm_i, with zeros elsewhere. Bits that would land above bit XLEN-1 are dropped.
- R8: When bit_en_i is low, op codes 0 to 7 give illegal_o = 1 and result_o = 0. Address ops are not affected by bit_en_i.
- R9: When addr_en_i is low, op codes 8 to 15 give illegal_o = 1 and result_o = 0. Single-bit ops are not affected by addr_en_i.
- R10: With XLEN = 32, op codes 11 to 15 are illegal, while op codes 8 to 10 stay legal.
- R11: Both outputs are registered. They reflect the inputs sampled at the previous rising clock edge, and they are zero while rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| rs1_i | input | XLEN | First source operand |
| rs2_i | input | XLEN | Second source operand or register bit index |
| imm_i | input | log2(XLEN) | Immediate bit index or shift amount |
| bit_en_i | input | 1 | Enable for the single-bit group |
| addr_en_i | input | 1 | Enable for the address-arithmetic group |
| result_o | output | XLEN | Registered result |
| illegal_o | output | 1 | Registered rejection flag |

## Verification
The bench builds two copies of the unit. The default XLEN = 64 copy reaches the index wrap at 64 and the word shift that drops bits past bit 63. It also covers the upper rs1 bits that the unsigned-word forms must mask off. A second copy with XLEN = 32 reaches the narrow configuration. There the unsigned-word codes must be rejected, while the plain scaled adds and the 5-bit index still work.

// File: rtl/sbsa_pkg.sv
package sbsa_pkg;
  typedef enum logic [3:0] {
    OP_BSET   = 4'd0,
    OP_BCLR   = 4'd1,
    OP_BINV   = 4'd2,
    OP_BEXT   = 4'd3,
    OP_BSETI  = 4'd4,
    OP_BCLRI  = 4'd5,
    OP_BINVI  = 4'd6,
    OP_BEXTI  = 4'd7,
    OP_SH1ADD = 4'd8,
    OP_SH2ADD = 4'd9,
    OP_SH3ADD = 4'd10,
    OP_SH1UW  = 4'd11,
    OP_SH2UW  = 4'd12,
    OP_SH3UW  = 4'd13,
    OP_ADDUW  = 4'd14,
    OP_SLLIUW = 4'd15
  } sbsa_op_e;

  localparam int OP_W = 4;
endpackage

// File: rtl/sbsa_bit_unit.sv
module sbsa_bit_unit #(
  parameter int XLEN = 64,
  localparam int IDX_W = $clog2(XLEN)
) (
  input  logic [1:0]       fn_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  rs1_i,
  output logic [XLEN-1:0]  res_o
);
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] shr;

  assign mask = {{(XLEN-1){1'b0}}, 1'b1} << idx_i;
  assign shr  = rs1_i >> idx_i;

  always_comb begin
    unique case (fn_i)
      2'd0:    res_o = rs1_i | mask;
      2'd1:    res_o = rs1_i & ~mask;
      2'd2:    res_o = rs1_i ^ mask;
      default: res_o = {{(XLEN-1){1'b0}}, shr[0]};
    endcase
  end
endmodule

// File: rtl/sbsa_addr_unit.sv
module sbsa_addr_unit #(
  parameter int XLEN = 64,
  localparam int IDX_W = $clog2(XLEN)
) (
  input  logic [2:0]       fn_i,
  input  logic [IDX_W-1:0] sh_i,
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [XLEN-1:0]  rs2_i,
  output logic [XLEN-1:0]  res_o
);
  logic [XLEN-1:0] zw;

  generate
    if (XLEN > 32) begin : g_wide
      assign zw = {{(XLEN-32){1'b0}}, rs1_i[31:0]};
    end else begin : g_narrow
      assign zw = rs1_i;
    end
  endgenerate

  always_comb begin
    unique case (fn_i)
      3'd0:    res_o = (rs1_i << 1) + rs2_i;
      3'd1:    res_o = (rs1_i << 2) + rs2_i;
      3'd2:    res_o = (rs1_i << 3) + rs2_i;
      3'd3:    res_o = (zw << 1) + rs2_i;
      3'd4:    res_o = (zw << 2) + rs2_i;
      3'd5:    res_o = (zw << 3) + rs2_i;
      3'd6:    res_o = zw + rs2_i;
      default: res_o = zw << sh_i;
    endcase
  end
endmodule

// File: rtl/sbsa_legal.sv
module sbsa_legal #(
  parameter int XLEN = 64
) (
  input  logic [3:0] op_i,
  input  logic       bit_en_i,
  input  logic       addr_en_i,
  output logic       legal_o
);
  logic uw_op;
  assign uw_op = op_i[3] && (op_i[2:0] >= 3'd3);

  generate
    if (XLEN == 64) begin : g_rv64
      assign legal_o = op_i[3] ? addr_en_i : bit_en_i;
    end else begin : g_rv32
      assign legal_o = op_i[3] ? (addr_en_i && !uw_op) : bit_en_i;
    end
  endgenerate
endmodule

// File: rtl/sbsa_unit.sv
module sbsa_unit #(
  parameter int XLEN = 64,
  localparam int IDX_W = $clog2(XLEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       op_i,
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [XLEN-1:0]  rs2_i,
  input  logic [IDX_W-1:0] imm_i,
  input  logic             bit_en_i,
  input  logic             addr_en_i,
  output logic [XLEN-1:0]  result_o,
  output logic             illegal_o
);
  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  bit_res;
  logic [XLEN-1:0]  addr_res;
  logic [XLEN-1:0]  res;
  logic             legal;

  // op[2] selects the immediate index form
  assign idx = op_i[2] ? imm_i : rs2_i[IDX_W-1:0];

  sbsa_bit_unit #(.XLEN(XLEN)) u_bit (
    .fn_i  (op_i[1:0]),
    .idx_i (idx),
    .rs1_i (rs1_i),
    .res_o (bit_res)
  );

  sbsa_addr_unit #(.XLEN(XLEN)) u_addr (
    .fn_i  (op_i[2:0]),
    .sh_i  (imm_i),
    .rs1_i (rs1_i),
    .rs2_i (rs2_i),
    .res_o (addr_res)
  );

  sbsa_legal #(.XLEN(XLEN)) u_legal (
    .op_i      (op_i),
    .bit_en_i  (bit_en_i),
    .addr_en_i (addr_en_i),
    .legal_o   (legal)
  );

  assign res = op_i[3] ? addr_res : bit_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      illegal_o <= !legal;
      result_o  <= legal ? res : '0;
    end
  end
endmodule

// File: rtl/sbsa_unit_chk.sv
module sbsa_unit_chk #(
  parameter int XLEN = 64,
  localparam int IDX_W = $clog2(XLEN)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       op_i,
  input logic [XLEN-1:0]  rs1_i,
  input logic [XLEN-1:0]  rs2_i,
  input logic [IDX_W-1:0] imm_i,
  input logic             bit_en_i,
  input logic             addr_en_i,
  input logic [XLEN-1:0]  result_o,
  input logic             illegal_o
);
  assert_illegal_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0));

  assert_bit_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_i[3] && !bit_en_i) |=> illegal_o);

  assert_addr_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[3] && !addr_en_i) |=> illegal_o);

  assert_ext_bit0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_i[3] && op_i[1:0] == 2'd3) |=> (result_o[XLEN-1:1] == '0));

  assert_inv_one_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd2 && bit_en_i) |=> ($countones(result_o ^ $past(rs1_i)) == 1));

  assert_set_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0 && bit_en_i) |=> result_o[$past(rs2_i[IDX_W-1:0])]);

  generate
    if (XLEN < 64) begin : g_narrow_chk
      assert_uw_narrow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i[3] && op_i[2:0] >= 3'd3) |=> illegal_o);
    end
  endgenerate
endmodule

bind sbsa_unit sbsa_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .rs1_i     (rs1_i),
  .rs2_i     (rs2_i),
  .imm_i     (imm_i),
  .bit_en_i  (bit_en_i),
  .addr_en_i (addr_en_i),
  .result_o  (result_o),
  .illegal_o (illegal_o)
);

// File: tb/tb_sbsa_unit.sv
module tb_sbsa_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] rs1 = '0, rs2 = '0;
  logic [5:0]  imm = '0;
  logic        ben = 1'b0, aen = 1'b0;
  logic [63:0] res;
  logic        ill;

  logic [3:0]  n_op = '0;
  logic [31:0] n_rs1 = '0, n_rs2 = '0;
  logic [4:0]  n_imm = '0;
  logic [31:0] n_res;
  logic        n_ill;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sbsa_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .rs1_i(rs1), .rs2_i(rs2),
    .imm_i(imm), .bit_en_i(ben), .addr_en_i(aen),
    .result_o(res), .illegal_o(ill)
  );

  sbsa_unit #(.XLEN(32)) dut_n (
    .clk_i(clk), .rst_ni(rst_n), .op_i(n_op), .rs1_i(n_rs1), .rs2_i(n_rs2),
    .imm_i(n_imm), .bit_en_i(1'b1), .addr_en_i(1'b1),
    .result_o(n_res), .illegal_o(n_ill)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample 1 after
  task automatic run(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                     input logic [5:0] i, input logic be, input logic ae);
    @(negedge clk);
    op = o; rs1 = a; rs2 = b; imm = i; ben = be; aen = ae;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] one_at(input int k);
    return 64'd1 << (k % 64);
  endfunction

  task automatic t_reset;
    chk("R11 reset result", res, 64'd0);
    chk("R11 reset illegal", {63'd0, ill}, 64'd0);
  endtask

  task automatic t_bitops;
    logic [63:0] a;
    a = 64'hA5A5_0F0F_3C3C_8001;
    run(4'd0, a, 64'd63, 6'd0, 1, 1);
    chk("R1 set 63", res, a | one_at(63));
    chk("R1 set legal", {63'd0, ill}, 64'd0);
    run(4'd1, a, 64'd0, 6'd0, 1, 1);
    chk("R1 clear 0", res, a & ~one_at(0));
    run(4'd2, a, 64'd10, 6'd0, 1, 1);
    chk("R1 invert 10", res, a ^ one_at(10));
    run(4'd0, a, 64'd70, 6'd0, 1, 1);
    chk("R3 wrap 70->6", res, a | one_at(6));
    run(4'd2, a, 64'hFFFF_FFFF_FFFF_FFC5, 6'd0, 1, 1);
    chk("R3 wrap upper rs2", res, a ^ one_at(5));
  endtask

  task automatic t_extract;
    logic [63:0] a;
    a = 64'h8000_0000_0000_0040;
    run(4'd3, a, 64'd63, 6'd0, 1, 1);
    chk("R2 extract 63", res, 64'd1);
    run(4'd3, a, 64'd62, 6'd0, 1, 1);
    chk("R2 extract 62", res, 64'd0);
    run(4'd7, a, 64'd0, 6'd6, 1, 1);
    chk("R2 R3 extract imm 6", res, 64'd1);
  endtask

  task automatic t_imm;
    logic [63:0] a;
    a = 64'h0123_4567_89AB_CDEF;
    run(4'd4, a, 64'd5, 6'd40, 1, 1);
    chk("R3 set imm 40", res, a | one_at(40));
    run(4'd5, a, 64'd0, 6'd0, 1, 1);
    chk("R3 clear imm 0", res, a & ~one_at(0));
    run(4'd6, a, 64'd1, 6'd63, 1, 1);
    chk("R3 invert imm 63", res, a ^ one_at(63));
  endtask

  task automatic t_shadd;
    logic [63:0] a, b;
    a = 64'hF000_0000_0000_1234;
    b = 64'h0000_0000_0000_0100;
    run(4'd8, a, b, 6'd0, 1, 1);
    chk("R4 sh1add", res, (a << 1) + b);
    run(4'd9, a, b, 6'd0, 1, 1);
    chk("R4 sh2add", res, (a << 2) + b);
    run(4'd10, a, b, 6'd0, 1, 1);
    chk("R4 sh3add", res, (a << 3) + b);
  endtask

  task automatic t_uw;
    logic [63:0] a, b, z;
    a = 64'hFFFF_FFFF_8000_0001;
    b = 64'h0000_0001_0000_0000;
    z = 64'h0000_0000_8000_0001;
    run(4'd11, a, b, 6'd0, 1, 1);
    chk("R5 sh1add uw", res, (z << 1) + b);
    run(4'd12, a, b, 6'd0, 1, 1);
    chk("R5 sh2add uw", res, (z << 2) + b);
    run(4'd13, a, b, 6'd0, 1, 1);
    chk("R5 sh3add uw", res, (z << 3) + b);
    run(4'd14, a, b, 6'd0, 1, 1);
    chk("R6 add uw", res, z + b);
    run(4'd15, 64'h1234_5678_FFFF_FFFF, 64'd0, 6'd40, 1, 1);
    chk("R7 slli uw drop", res, 64'hFFFF_FF00_0000_0000);
    run(4'd15, a, 64'd0, 6'd4, 1, 1);
    chk("R7 slli uw 4", res, 64'h0000_0008_0000_0010);
  endtask

  task automatic t_gate;
    run(4'd0, 64'h0, 64'd3, 6'd0, 0, 1);
    chk("R8 bit gated result", res, 64'd0);
    chk("R8 bit gated illegal", {63'd0, ill}, 64'd1);
    run(4'd7, 64'hFFFF, 64'd0, 6'd0, 0, 1);
    chk("R8 ext imm gated", {res[62:0], ill}, 64'd1);
    run(4'd8, 64'd4, 64'd1, 6'd0, 0, 1);
    chk("R8 addr unaffected", res, 64'd9);
    run(4'd14, 64'd4, 64'd1, 6'd0, 1, 0);
    chk("R9 addr gated result", res, 64'd0);
    chk("R9 addr gated illegal", {63'd0, ill}, 64'd1);
    run(4'd2, 64'd0, 64'd1, 6'd0, 1, 0);
    chk("R9 bit unaffected", res, 64'd2);
    chk("R9 bit unaffected legal", {63'd0, ill}, 64'd0);
  endtask

  task automatic t_narrow;
    @(negedge clk);
    n_op = 4'd8; n_rs1 = 32'h8000_0003; n_rs2 = 32'd5;
    @(posedge clk); #1;
    chk("R10 narrow sh1add", {32'd0, n_res}, 64'd11);
    chk("R10 narrow sh1add legal", {63'd0, n_ill}, 64'd0);
    @(negedge clk);
    n_op = 4'd11;
    @(posedge clk); #1;
    chk("R10 narrow uw illegal", {31'd0, n_res, n_ill}, 64'd1);
    @(negedge clk);
    n_op = 4'd15; n_imm = 5'd3;
    @(posedge clk); #1;
    chk("R10 narrow slli uw illegal", {63'd0, n_ill}, 64'd1);
    @(negedge clk);
    n_op = 4'd0; n_rs1 = 32'd0; n_rs2 = 32'd33;
    @(posedge clk); #1;
    chk("R10 R3 narrow wrap 33->1", {32'd0, n_res}, 64'd2);
  endtask

  task automatic t_hold;
    run(4'd8, 64'd1, 64'd1, 6'd0, 1, 1);
    @(negedge clk);
    op = 4'd9;
    chk("R11 no change before edge", res, 64'd3);
    @(posedge clk); #1;
    chk("R11 update after edge", res, 64'd5);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset;
    rst_n = 1'b1;
    t_bitops;
    t_extract;
    t_imm;
    t_shadd;
    t_uw;
    t_gate;
    t_narrow;
    t_hold;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule